// File: doc/BRIEF.md
# Multi-Channel Byte Block-Transfer Engine

This block moves bursts of bytes between a wide memory bus and a narrow register page. It has eight channels by default. Each channel holds its own setup: a control byte, an 8-bit register offset, a 16-bit address inside an 8-bit bank, and a 16-bit byte count. Software programs the channels through a small configuration port. A single write to the launch port then names the channels to run. The engine serves them one after another, lowest channel first. Each byte is carried as two steps: one read on the source side into a holding byte, then one write on the other side.

The memory side is a 24-bit address bus. The register side is a 16-bit bus fixed at page 0x21xx. Each side has a request/acknowledge byte handshake. The engine steps the register offset through one of several patterns. It steps the memory address up, down or not at all. When a channel ends, it writes its final address back and clears its count. Two address windows of the memory bus are protected: a read there yields 0x00 and never reaches the bus.

Top module: `gdma_engine`

## Requirements
- R1: Channels named in a launch mask are served one at a time in ascending channel order (0 first). Each channel finishes before the next one starts.
- R2: `busy` is 0 after reset. It rises on the clock edge that accepts a non-zero launch write and falls after the last named channel ends. A launch write while busy is ignored. `launch_q` shows the channels still pending and reads all zero once the engine is idle.
- R3: Control bit 7 chooses the direction. With 0, the engine reads the memory bus and writes the register bus. With 1, it reads the register bus and writes the memory bus.
- R4: Every register-bus access uses address 0x2100 + offset + k, where k is the pattern step given in R5.
- R5: Control bits [2:0] choose the pattern of k, restarting from the first byte of each channel. Modes 0, 2 and 6 give 0,0,0,… Modes 1 and 5 give 0,1,0,1,… Modes 3 and 7 give 0,0,1,1,… Mode 4 gives 0,1,2,3,…
- R6: The count drops by one per byte. The channel stops as soon as the count reaches zero, even in the middle of a pattern group.
- R7: A channel that starts with a count of 0 moves 65536 bytes.
- R8: After each byte the memory address changes only in its low 16 bits. Control bit 3 = 1 keeps it fixed. Otherwise control bit 4 = 1 decrements it and 0 increments it. The low 16 bits wrap inside the bank, and the bank byte is never altered.
- R9: When a channel ends, its address register holds the address after the last step, and its count register reads 0.
- R10: A memory-bus read aimed at an address with (addr & 0x40FF00) == 0x002100, or with (addr & 0x40FE00) == 0x004000, raises no request and delivers byte 0x00.
- R11: Each byte makes exactly one source-side access followed by one destination-side access. The two buses are never requested in the same cycle, and a request holds its address until it is acknowledged.
- R12: The configuration port selects a field with `cfg_fld`: 0 control, 1 offset, 2 address low, 3 address high, 4 bank, 5 count low, 6 count high, 7 reads 0. All fields are 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Write strobe for a channel field |
| cfg_ch | input | 3 | Channel selected for configuration read/write |
| cfg_fld | input | 3 | Field selected (see R12) |
| cfg_wdata | input | 8 | Field write data |
| cfg_rdata | output | 8 | Field read data (combinational) |
| launch_we | input | 1 | Launch strobe |
| launch_mask | input | 8 | Channels to run, one bit per channel |
| launch_q | output | 8 | Channels still pending |
| busy | output | 1 | Engine is running |
| a_req | output | 1 | Memory-bus request |
| a_we | output | 1 | Memory-bus write (1) or read (0) |
| a_addr | output | 24 | Memory-bus address |
| a_wdata | output | 8 | Memory-bus write data |
| a_rdata | input | 8 | Memory-bus read data |
| a_ack | input | 1 | Memory-bus acknowledge |
| b_req | output | 1 | Register-bus request |
| b_we | output | 1 | Register-bus write (1) or read (0) |
| b_addr | output | 16 | Register-bus address |
| b_wdata | output | 8 | Register-bus write data |
| b_rdata | input | 8 | Register-bus read data |
| b_ack | input | 1 | Register-bus acknowledge |

## Verification
The assertions assume two things. Acknowledges arrive only while the matching request is high. No channel is reprogrammed while the engine is busy. They also assume every offset stays at or below 0xFC, so that the highest pattern step still lands in page 0x21. The stimulus respects all of this. It ties each acknowledge to its request, writes configuration only between runs, and uses offsets well under 0xFC.

// File: rtl/gdma_pkg.sv
package gdma_pkg;

  typedef struct packed {
    logic [7:0]  ctrl;
    logic [7:0]  off;
    logic [15:0] src;
    logic [7:0]  bank;
    logic [15:0] cnt;
  } chan_t;

  typedef enum logic [2:0] {
    FLD_CTRL = 3'd0,
    FLD_OFF  = 3'd1,
    FLD_SRCL = 3'd2,
    FLD_SRCH = 3'd3,
    FLD_BANK = 3'd4,
    FLD_CNTL = 3'd5,
    FLD_CNTH = 3'd6,
    FLD_NONE = 3'd7
  } fld_e;

  localparam logic [15:0] REG_PAGE = 16'h2100;

  // register-offset step for byte index phase within a pattern group
  function automatic logic [1:0] pat_step(input logic [2:0] mode, input logic [1:0] ph);
    case (mode)
      3'd1, 3'd5: return {1'b0, ph[0]};
      3'd3, 3'd7: return {1'b0, ph[1]};
      3'd4:       return ph;
      default:    return 2'd0;
    endcase
  endfunction

  function automatic logic [15:0] step_addr(input logic [15:0] a, input logic fix, input logic dec);
    if (fix)      return a;
    else if (dec) return a - 16'd1;
    else          return a + 16'd1;
  endfunction

  function automatic logic is_forbidden(input logic [23:0] a);
    return ((a & 24'h40FF00) == 24'h002100) || ((a & 24'h40FE00) == 24'h004000);
  endfunction

endpackage

// File: rtl/gdma_regs.sv
module gdma_regs
  import gdma_pkg::*;
#(
  parameter int NCH = 8,
  parameter int CW  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CW-1:0]     cfg_ch,
  input  logic [2:0]        cfg_fld,
  input  logic [7:0]        cfg_wdata,
  output logic [7:0]        cfg_rdata,
  input  logic              wb_en,
  input  logic [CW-1:0]     wb_ch,
  input  logic [15:0]       wb_src,
  output chan_t [NCH-1:0]   chans
);

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    chan_t r_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        r_q <= '0;
      end else if (wb_en && wb_ch == CW'(g)) begin
        r_q.src <= wb_src;
        r_q.cnt <= 16'd0;
      end else if (cfg_we && cfg_ch == CW'(g)) begin
        case (fld_e'(cfg_fld))
          FLD_CTRL: r_q.ctrl       <= cfg_wdata;
          FLD_OFF:  r_q.off        <= cfg_wdata;
          FLD_SRCL: r_q.src[7:0]   <= cfg_wdata;
          FLD_SRCH: r_q.src[15:8]  <= cfg_wdata;
          FLD_BANK: r_q.bank       <= cfg_wdata;
          FLD_CNTL: r_q.cnt[7:0]   <= cfg_wdata;
          FLD_CNTH: r_q.cnt[15:8]  <= cfg_wdata;
          default: ;
        endcase
      end
    end
    assign chans[g] = r_q;
  end

  chan_t rsel;
  always_comb begin
    rsel = chans[cfg_ch];
    case (fld_e'(cfg_fld))
      FLD_CTRL: cfg_rdata = rsel.ctrl;
      FLD_OFF:  cfg_rdata = rsel.off;
      FLD_SRCL: cfg_rdata = rsel.src[7:0];
      FLD_SRCH: cfg_rdata = rsel.src[15:8];
      FLD_BANK: cfg_rdata = rsel.bank;
      FLD_CNTL: cfg_rdata = rsel.cnt[7:0];
      FLD_CNTH: cfg_rdata = rsel.cnt[15:8];
      default:  cfg_rdata = 8'h00;
    endcase
  end

endmodule

// File: rtl/gdma_seq.sv
module gdma_seq
  import gdma_pkg::*;
#(
  parameter int NCH = 8,
  parameter int CW  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch_we,
  input  logic [NCH-1:0]    launch_mask,
  input  chan_t [NCH-1:0]   chans,
  output logic [NCH-1:0]    pend_q,
  output logic              busy,
  output logic              a_req,
  output logic              a_we,
  output logic [23:0]       a_addr,
  output logic [7:0]        a_wdata,
  input  logic [7:0]        a_rdata,
  input  logic              a_ack,
  output logic              b_req,
  output logic              b_we,
  output logic [15:0]       b_addr,
  output logic [7:0]        b_wdata,
  input  logic [7:0]        b_rdata,
  input  logic              b_ack,
  output logic              wb_en,
  output logic [CW-1:0]     wb_ch,
  output logic [15:0]       wb_src
);

  typedef enum logic [1:0] {ST_IDLE, ST_SEL, ST_RD, ST_WR} st_e;

  function automatic logic [CW-1:0] first_set(input logic [NCH-1:0] m);
    logic [CW-1:0] r;
    r = '0;
    for (int i = NCH - 1; i >= 0; i--) if (m[i]) r = CW'(i);
    return r;
  endfunction

  st_e           state_q;
  logic [CW-1:0] cur_q;
  logic [15:0]   addr_q;
  logic [15:0]   cnt_q;
  logic [1:0]    ph_q;
  logic [7:0]    hold_q;

  chan_t         cur_c;
  chan_t         sel_c;
  logic [CW-1:0] sel_ch;
  logic          dir_up;
  logic          forb;
  logic          rd_done;
  logic          wr_done;
  logic          last_byte;
  logic [7:0]    rd_byte;
  logic [NCH-1:0] pend_left;

  assign cur_c     = chans[cur_q];
  assign sel_ch    = first_set(pend_q);
  assign sel_c     = chans[sel_ch];
  assign dir_up    = cur_c.ctrl[7];
  assign a_addr    = {cur_c.bank, addr_q};
  assign forb      = is_forbidden(a_addr);
  assign b_addr    = REG_PAGE + {8'h00, cur_c.off} + {14'd0, pat_step(cur_c.ctrl[2:0], ph_q)};
  assign last_byte = (cnt_q == 16'd1);
  assign rd_done   = (state_q == ST_RD) && (dir_up ? b_ack : (forb || a_ack));
  assign wr_done   = (state_q == ST_WR) && (dir_up ? a_ack : b_ack);
  assign rd_byte   = dir_up ? b_rdata : (forb ? 8'h00 : a_rdata);
  assign pend_left = pend_q & ~(NCH'(1) << cur_q);

  assign busy    = (state_q != ST_IDLE);
  assign a_req   = ((state_q == ST_RD) && !dir_up && !forb) || ((state_q == ST_WR) && dir_up);
  assign a_we    = (state_q == ST_WR);
  assign a_wdata = hold_q;
  assign b_req   = ((state_q == ST_RD) && dir_up) || ((state_q == ST_WR) && !dir_up);
  assign b_we    = (state_q == ST_WR);
  assign b_wdata = hold_q;

  assign wb_en   = wr_done && last_byte;
  assign wb_ch   = cur_q;
  assign wb_src  = step_addr(addr_q, cur_c.ctrl[3], cur_c.ctrl[4]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pend_q  <= '0;
      cur_q   <= '0;
      addr_q  <= '0;
      cnt_q   <= '0;
      ph_q    <= '0;
      hold_q  <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (launch_we && |launch_mask) begin
          pend_q  <= launch_mask;
          state_q <= ST_SEL;
        end
        ST_SEL: begin
          cur_q   <= sel_ch;
          addr_q  <= sel_c.src;
          cnt_q   <= sel_c.cnt;
          ph_q    <= 2'd0;
          state_q <= ST_RD;
        end
        ST_RD: if (rd_done) begin
          hold_q  <= rd_byte;
          state_q <= ST_WR;
        end
        ST_WR: if (wr_done) begin
          addr_q <= wb_src;
          cnt_q  <= cnt_q - 16'd1;
          ph_q   <= ph_q + 2'd1;
          if (last_byte) begin
            pend_q  <= pend_left;
            state_q <= (pend_left == '0) ? ST_IDLE : ST_SEL;
          end else begin
            state_q <= ST_RD;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/gdma_engine.sv
module gdma_engine
  import gdma_pkg::*;
#(
  parameter int NCH = 8,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_we,
  input  logic [CW-1:0]  cfg_ch,
  input  logic [2:0]     cfg_fld,
  input  logic [7:0]     cfg_wdata,
  output logic [7:0]     cfg_rdata,
  input  logic           launch_we,
  input  logic [NCH-1:0] launch_mask,
  output logic [NCH-1:0] launch_q,
  output logic           busy,
  output logic           a_req,
  output logic           a_we,
  output logic [23:0]    a_addr,
  output logic [7:0]     a_wdata,
  input  logic [7:0]     a_rdata,
  input  logic           a_ack,
  output logic           b_req,
  output logic           b_we,
  output logic [15:0]    b_addr,
  output logic [7:0]     b_wdata,
  input  logic [7:0]     b_rdata,
  input  logic           b_ack
);

  chan_t [NCH-1:0] chans;
  logic            wb_en;
  logic [CW-1:0]   wb_ch;
  logic [15:0]     wb_src;

  gdma_regs #(.NCH(NCH), .CW(CW)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_fld(cfg_fld),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .wb_en(wb_en), .wb_ch(wb_ch), .wb_src(wb_src),
    .chans(chans)
  );

  gdma_seq #(.NCH(NCH), .CW(CW)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .launch_we(launch_we), .launch_mask(launch_mask),
    .chans(chans), .pend_q(launch_q), .busy(busy),
    .a_req(a_req), .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata),
    .a_rdata(a_rdata), .a_ack(a_ack),
    .b_req(b_req), .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wdata),
    .b_rdata(b_rdata), .b_ack(b_ack),
    .wb_en(wb_en), .wb_ch(wb_ch), .wb_src(wb_src)
  );

endmodule

// File: rtl/gdma_engine_chk.sv
module gdma_engine_chk #(
  parameter int NCH = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           busy,
  input logic [NCH-1:0] launch_q,
  input logic           a_req,
  input logic           a_we,
  input logic [23:0]    a_addr,
  input logic           a_ack,
  input logic           b_req,
  input logic [15:0]    b_addr,
  input logic           b_ack
);

  p_one_side_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(a_req && b_req));

  p_a_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (a_req && !a_ack) |=> (a_req && $stable(a_addr)));

  p_b_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (b_req && !b_ack) |=> (b_req && $stable(b_addr)));

  p_idle_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (launch_q == '0));

  p_no_forb_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (a_req && !a_we) |-> !gdma_pkg::is_forbidden(a_addr));

  p_bpage_r4: assert property (@(posedge clk) disable iff (!rst_n)
    b_req |-> (b_addr[15:8] == 8'h21));

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!a_req && !b_req));

endmodule

bind gdma_engine gdma_engine_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .launch_q(launch_q),
  .a_req(a_req), .a_we(a_we), .a_addr(a_addr), .a_ack(a_ack),
  .b_req(b_req), .b_addr(b_addr), .b_ack(b_ack)
);

// File: tb/gdma_engine_tb.sv
module gdma_engine_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NCH = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [2:0] cfg_ch = '0;
  logic [2:0] cfg_fld = '0;
  logic [7:0] cfg_wdata = '0;
  logic [7:0] cfg_rdata;
  logic launch_we = 1'b0;
  logic [NCH-1:0] launch_mask = '0;
  logic [NCH-1:0] launch_q;
  logic busy;
  logic a_req, a_we, b_req, b_we;
  logic [23:0] a_addr;
  logic [15:0] b_addr;
  logic [7:0] a_wdata, b_wdata, a_rdata, b_rdata;
  logic a_ack, b_ack;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] mem_byte(input logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h3C;
  endfunction

  assign a_ack   = a_req;
  assign b_ack   = b_req;
  assign a_rdata = mem_byte(a_addr);
  assign b_rdata = b_addr[7:0] + 8'h40;

  gdma_engine #(.NCH(NCH)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_fld(cfg_fld),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .launch_we(launch_we),
    .launch_mask(launch_mask), .launch_q(launch_q), .busy(busy),
    .a_req(a_req), .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata),
    .a_rdata(a_rdata), .a_ack(a_ack), .b_req(b_req), .b_we(b_we),
    .b_addr(b_addr), .b_wdata(b_wdata), .b_rdata(b_rdata), .b_ack(b_ack)
  );

  // bus activity logs
  logic clr_log = 1'b0;
  int a_rd_n, a_wr_n, b_rd_n, b_wr_n;
  logic [23:0] alog_addr [64];
  logic [7:0]  alog_data [64];
  logic [15:0] blog_addr [64];
  logic [7:0]  blog_data [64];
  logic [23:0] arlog_addr [64];
  logic [15:0] brlog_addr [64];

  always @(posedge clk) begin
    if (clr_log) begin
      a_rd_n <= 0; a_wr_n <= 0; b_rd_n <= 0; b_wr_n <= 0;
    end else begin
      if (a_req && a_ack && !a_we) begin
        if (a_rd_n < 64) arlog_addr[a_rd_n] <= a_addr;
        a_rd_n <= a_rd_n + 1;
      end
      if (a_req && a_ack && a_we) begin
        if (a_wr_n < 64) begin alog_addr[a_wr_n] <= a_addr; alog_data[a_wr_n] <= a_wdata; end
        a_wr_n <= a_wr_n + 1;
      end
      if (b_req && b_ack && !b_we) begin
        if (b_rd_n < 64) brlog_addr[b_rd_n] <= b_addr;
        b_rd_n <= b_rd_n + 1;
      end
      if (b_req && b_ack && b_we) begin
        if (b_wr_n < 64) begin blog_addr[b_wr_n] <= b_addr; blog_data[b_wr_n] <= b_wdata; end
        b_wr_n <= b_wr_n + 1;
      end
    end
  end

  int n_chk = 0;
  int n_bad = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic clear_logs();
    @(negedge clk); clr_log = 1'b1;
    @(negedge clk); clr_log = 1'b0;
  endtask

  task automatic wr_fld(input int ch, input int fld, input logic [7:0] d);
    @(negedge clk);
    cfg_ch = 3'(ch); cfg_fld = 3'(fld); cfg_wdata = d; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd_fld(input int ch, input int fld, output logic [7:0] d);
    cfg_ch = 3'(ch); cfg_fld = 3'(fld);
    #1 d = cfg_rdata;
  endtask

  task automatic prog(input int ch, input logic [7:0] ctrl, input logic [7:0] off,
                      input logic [15:0] src, input logic [7:0] bank, input logic [15:0] cnt);
    wr_fld(ch, 0, ctrl);
    wr_fld(ch, 1, off);
    wr_fld(ch, 2, src[7:0]);
    wr_fld(ch, 3, src[15:8]);
    wr_fld(ch, 4, bank);
    wr_fld(ch, 5, cnt[7:0]);
    wr_fld(ch, 6, cnt[15:8]);
  endtask

  task automatic launch(input logic [7:0] m);
    @(negedge clk);
    launch_mask = m; launch_we = 1'b1;
    @(negedge clk);
    launch_we = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic rd_src_cnt(input int ch, output logic [15:0] s, output logic [15:0] c);
    logic [7:0] lo, hi;
    rd_fld(ch, 2, lo); rd_fld(ch, 3, hi); s = {hi, lo};
    rd_fld(ch, 5, lo); rd_fld(ch, 6, hi); c = {hi, lo};
  endtask

  // bench's own view of the offset cycle per mode
  function automatic int exp_k(input int mode, input int idx);
    if (mode == 4) return idx % 4;
    if (mode == 1 || mode == 5) return idx % 2;
    if (mode == 3 || mode == 7) return (idx / 2) % 2;
    return 0;
  endfunction

  task automatic t_reset();
    logic [7:0] d;
    check(busy == 1'b0, "R2", "busy after reset", busy, 0);
    check(launch_q == 8'h00, "R2", "launch_q after reset", launch_q, 0);
    check(!a_req && !b_req, "R11", "no request after reset", {a_req, b_req}, 0);
    for (int f = 0; f < 8; f++) begin
      rd_fld(3, f, d);
      check(d == 8'h00, "R12", "field reset value", d, 0);
    end
  endtask

  task automatic t_modes();
    for (int m = 0; m < 8; m++) begin
      int bad;
      bad = 0;
      prog(0, 8'(m), 8'h18, 16'h8000, 8'h01, 16'd8);
      clear_logs();
      launch(8'h01);
      wait_idle();
      check(b_wr_n == 8 && a_rd_n == 8, "R11", "one read and one write per byte",
            b_wr_n * 100 + a_rd_n, 808);
      for (int k = 0; k < 8; k++) begin
        logic [15:0] eb;
        logic [7:0] ed;
        eb = 16'h2100 + 16'h18 + 16'(exp_k(m, k));
        ed = mem_byte(24'h018000 + 24'(k));
        if (blog_addr[k] != eb || blog_data[k] != ed) begin
          bad++;
          check(1'b0, "R5", "pattern byte addr/data", {blog_addr[k], blog_data[k]}, {eb, ed});
        end
      end
      check(bad == 0, "R4", "register page addresses for mode", bad, 0);
    end
  endtask

  task automatic t_partial();
    prog(2, 8'h04, 8'h30, 16'h0100, 8'h02, 16'd3);
    clear_logs();
    launch(8'h04);
    wait_idle();
    check(b_wr_n == 3, "R6", "mode 4 stops after 3 bytes", b_wr_n, 3);
    check(blog_addr[2] == 16'h2132, "R6", "third offset in group", blog_addr[2], 16'h2132);
    prog(2, 8'h03, 8'h30, 16'h0100, 8'h02, 16'd5);
    clear_logs();
    launch(8'h04);
    wait_idle();
    check(b_wr_n == 5, "R6", "mode 3 stops after 5 bytes", b_wr_n, 5);
    check(blog_addr[4] == 16'h2130, "R6", "fifth byte starts new group", blog_addr[4], 16'h2130);
  endtask

  task automatic t_dir();
    logic [15:0] s, c;
    int bad;
    bad = 0;
    prog(1, 8'h81, 8'h22, 16'h1234, 8'h7E, 16'd4);
    clear_logs();
    launch(8'h02);
    wait_idle();
    check(a_wr_n == 4 && b_rd_n == 4 && a_rd_n == 0 && b_wr_n == 0, "R3",
          "reverse direction bus use", {a_wr_n[7:0], b_rd_n[7:0], a_rd_n[7:0], b_wr_n[7:0]}, 32'h04040000);
    for (int k = 0; k < 4; k++) begin
      logic [15:0] eb;
      eb = 16'h2122 + 16'(k % 2);
      if (brlog_addr[k] != eb || alog_addr[k] != 24'h7E1234 + 24'(k) ||
          alog_data[k] != eb[7:0] + 8'h40) bad++;
    end
    check(bad == 0, "R3", "register-to-memory bytes", bad, 0);
    rd_src_cnt(1, s, c);
    check(s == 16'h1238 && c == 16'h0, "R9", "write-back after reverse run", {s, c}, 32'h12380000);
  endtask

  task automatic t_step();
    logic [15:0] s, c;
    prog(4, 8'h10, 8'h05, 16'h0001, 8'h05, 16'd3);
    clear_logs(); launch(8'h10); wait_idle();
    check(arlog_addr[0] == 24'h050001 && arlog_addr[1] == 24'h050000 && arlog_addr[2] == 24'h05FFFF,
          "R8", "decrement wraps within bank", arlog_addr[2], 24'h05FFFF);
    rd_src_cnt(4, s, c);
    check(s == 16'hFFFE && c == 16'h0, "R9", "write-back after decrement", {s, c}, 32'hFFFE0000);
    prog(4, 8'h18, 8'h05, 16'h9000, 8'h05, 16'd3);
    clear_logs(); launch(8'h10); wait_idle();
    check(arlog_addr[0] == 24'h059000 && arlog_addr[2] == 24'h059000, "R8", "fixed address",
          arlog_addr[2], 24'h059000);
    rd_src_cnt(4, s, c);
    check(s == 16'h9000, "R9", "fixed address write-back", s, 16'h9000);
    prog(4, 8'h00, 8'h05, 16'hFFFE, 8'h05, 16'd3);
    clear_logs(); launch(8'h10); wait_idle();
    check(arlog_addr[2] == 24'h050000, "R8", "increment wraps, bank kept", arlog_addr[2], 24'h050000);
    rd_src_cnt(4, s, c);
    check(s == 16'h0001 && c == 16'h0, "R9", "write-back after wrap", {s, c}, 32'h00010000);
  endtask

  task automatic t_order();
    int bad;
    bad = 0;
    prog(6, 8'h00, 8'h60, 16'h0200, 8'h01, 16'd1);
    prog(1, 8'h00, 8'h10, 16'h0200, 8'h01, 16'd2);
    prog(3, 8'h00, 8'h30, 16'h0200, 8'h01, 16'd1);
    clear_logs();
    launch(8'h4A);
    wait_idle();
    check(b_wr_n == 4, "R1", "total bytes of three channels", b_wr_n, 4);
    if (blog_addr[0] != 16'h2110 || blog_addr[1] != 16'h2110 ||
        blog_addr[2] != 16'h2130 || blog_addr[3] != 16'h2160) bad++;
    check(bad == 0, "R1", "ascending channel order", blog_addr[3], 16'h2160);
    check(launch_q == 8'h00, "R2", "launch status zero after run", launch_q, 0);
  endtask

  task automatic t_forbidden();
    prog(5, 8'h00, 8'h40, 16'h20FF, 8'h00, 16'd3);
    clear_logs(); launch(8'h20); wait_idle();
    check(a_rd_n == 1 && b_wr_n == 3, "R10", "one real read, three writes", a_rd_n, 1);
    check(blog_data[0] == mem_byte(24'h0020FF) && blog_data[1] == 8'h00 && blog_data[2] == 8'h00,
          "R10", "blocked window yields zero", {blog_data[1], blog_data[2]}, 0);
    prog(5, 8'h00, 8'h40, 16'h41FE, 8'h80, 16'd3);
    clear_logs(); launch(8'h20); wait_idle();
    check(a_rd_n == 1 && arlog_addr[0] == 24'h804200, "R10", "second window blocked",
          arlog_addr[0], 24'h804200);
    prog(5, 8'h00, 8'h40, 16'h2100, 8'h40, 16'd1);
    clear_logs(); launch(8'h20); wait_idle();
    check(a_rd_n == 1, "R10", "bank bit 6 set is not blocked", a_rd_n, 1);
  endtask

  task automatic t_busy();
    prog(0, 8'h00, 8'h08, 16'h0300, 8'h01, 16'd10);
    prog(1, 8'h00, 8'h09, 16'h0300, 8'h01, 16'd4);
    clear_logs();
    @(negedge clk);
    launch_mask = 8'h01; launch_we = 1'b1;
    @(negedge clk);
    launch_we = 1'b0;
    check(busy == 1'b1, "R2", "busy after accepted launch", busy, 1);
    @(negedge clk);
    launch_mask = 8'h02; launch_we = 1'b1;
    @(negedge clk);
    launch_we = 1'b0;
    check(launch_q == 8'h01, "R2", "launch while busy ignored", launch_q, 8'h01);
    wait_idle();
    check(b_wr_n == 10, "R2", "ignored channel did not run", b_wr_n, 10);
  endtask

  task automatic t_zero();
    logic [15:0] s, c;
    prog(7, 8'h08, 8'h50, 16'h3000, 8'h01, 16'd0);
    clear_logs();
    launch(8'h80);
    repeat (1000) @(negedge clk);
    check(busy == 1'b1, "R7", "zero count still running", busy, 1);
    wait_idle();
    check(b_wr_n == 65536, "R7", "zero count moves 65536 bytes", b_wr_n, 65536);
    rd_src_cnt(7, s, c);
    check(s == 16'h3000 && c == 16'h0, "R9", "write-back after long run", {s, c}, 32'h30000000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_modes();
    t_partial();
    t_dir();
    t_step();
    t_order();
    t_forbidden();
    t_busy();
    t_zero();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: run did not finish, actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule